// File: doc/BRIEF.md
# Host-to-Processor Command Mailbox

This block sits between a byte-wide host register port and an embedded acquisition processor. The host fills a small shared buffer with a command packet through a single data register. A buffer pointer advances on every access to that register. The host then raises a request-pending flag. The processor reads the packet from its own buffer port, writes its reply into the same buffer, and pulses a done strobe. The done strobe drops the flag, so the host can poll for completion and read the reply back through the same data register.

A request packet opens with a command byte, then a message-identifier byte, then the payload. A reply carries two header bytes ahead of its payload. The block moves bytes and does not interpret packet contents. The block also holds the processor's reset control bit and reports the processor's reset acknowledge and run indications.

The register port has no back-pressure. A write or read strobe is accepted in every cycle it is high. Read data returns on the following cycle and holds until the next read.

Top module: `mbx_host_if`

## Requirements
- R1: After reset, the request flag, the processor reset output and the buffer pointer are all 0, and reading 0xA8, 0xA0, 0xA6 or 0xA2 (with both processor indications low) returns 0x00.
- R2: A write to 0xA6 loads the buffer pointer from the low 6 bits of the write data. A read of 0xA6 returns the pointer value.
- R3: A write to 0xA7 stores the byte at the pointer and then adds one to the pointer. From the next cycle, the byte is visible on the processor buffer read port at that address.
- R4: A read strobe on 0xA7 returns the byte at the pointer on reg_rdata one cycle later and adds one to the pointer.
- R5: The pointer wraps from 63 to 0 on both reads and writes of 0xA7.
- R6: In 0xA8, bit 0 is the request flag and bit 1 is its load enable. A write changes the flag to bit 0 only when bit 1 is 1. Reads return the flag in bit 0 and zeros elsewhere. The flag drives ap_req_pending.
- R7: An ap_done pulse clears the flag on the next edge. When ap_done and a flag-loading write to 0xA8 occur in the same cycle, the flag ends at 0.
- R8: Bit 0 of 0xA0 drives ap_reset on the next edge and reads back from 0xA0.
- R9: A read of 0xA2 returns ap_reset_ack in bit 0 and ap_running in bit 1, with zeros elsewhere.
- R10: Any address other than 0xA0, 0xA2, 0xA6, 0xA7 and 0xA8 reads as 0x00. Reads of addresses other than 0xA7 leave the pointer unchanged.
- R11: A processor-side buffer write stores its byte at ap_buf_addr, and the host can read that byte through 0xA7. If the host and the processor write the same address in the same cycle, the host's byte is kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_addr | input | 8 | Host register address |
| reg_wdata | input | 8 | Host write data |
| reg_we | input | 1 | Host write strobe |
| reg_re | input | 1 | Host read strobe |
| reg_rdata | output | 8 | Host read data, valid the cycle after reg_re |
| ap_req_pending | output | 1 | Request flag toward the processor |
| ap_done | input | 1 | Processor completion strobe; clears the flag |
| ap_buf_addr | input | 6 | Processor buffer address |
| ap_buf_we | input | 1 | Processor buffer write enable |
| ap_buf_wdata | input | 8 | Processor buffer write data |
| ap_buf_rdata | output | 8 | Processor buffer read data, combinational from ap_buf_addr |
| ap_reset | output | 1 | Holds the processor in reset while high |
| ap_reset_ack | input | 1 | Processor reports that it is in reset |
| ap_running | input | 1 | Processor reports that it is executing |

## Verification
Host register reads are due on reg_rdata one edge after the strobe is sampled. The bench's monitor records the strobe at that edge and compares shortly after it, against the next queued expectation. Register writes, the flag and ap_reset change on the edge that samples the strobe or ap_done, so their checks run at the falling edge that follows. The processor read port is combinational, so the bench checks it one time step after ap_buf_addr changes, once the write has had an edge to land.

// File: rtl/mbx_pkg.sv
package mbx_pkg;
  localparam int unsigned REG_W = 8;
  // Register addresses the host software decodes.
  localparam logic [REG_W-1:0] ADDR_CTRL   = 8'hA0;
  localparam logic [REG_W-1:0] ADDR_APSTAT = 8'hA2;
  localparam logic [REG_W-1:0] ADDR_PTR    = 8'hA6;
  localparam logic [REG_W-1:0] ADDR_DATA   = 8'hA7;
  localparam logic [REG_W-1:0] ADDR_FLAG   = 8'hA8;
  // Bit positions.
  localparam int unsigned FLAG_BIT  = 0;
  localparam int unsigned LOAD_BIT  = 1;
  localparam int unsigned RST_BIT   = 0;
  localparam int unsigned ACK_BIT   = 0;
  localparam int unsigned RUN_BIT   = 1;

  typedef enum logic [2:0] {
    SEL_NONE, SEL_CTRL, SEL_APSTAT, SEL_PTR, SEL_DATA, SEL_FLAG
  } reg_sel_e;

  function automatic reg_sel_e decode(input logic [REG_W-1:0] a);
    unique case (a)
      ADDR_CTRL:   decode = SEL_CTRL;
      ADDR_APSTAT: decode = SEL_APSTAT;
      ADDR_PTR:    decode = SEL_PTR;
      ADDR_DATA:   decode = SEL_DATA;
      ADDR_FLAG:   decode = SEL_FLAG;
      default:     decode = SEL_NONE;
    endcase
  endfunction
endpackage

// File: rtl/mbx_ptr.sv
module mbx_ptr #(
  parameter int unsigned PTR_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [PTR_W-1:0] load_val,
  input  logic             step,
  output logic [PTR_W-1:0] ptr
);
  always_ff @(posedge clk) begin
    if (!rst_n)    ptr <= '0;
    else if (load) ptr <= load_val;
    else if (step) ptr <= ptr + 1'b1;
  end

  assert_ptr_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> ptr == $past(load_val));
  // R3 and R4 step the pointer; modulo arithmetic gives the R5 wrap
  assert_ptr_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && step) |=> ptr == PTR_W'($past(ptr) + 1'b1));
  assert_ptr_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && !step) |=> $stable(ptr));
endmodule

// File: rtl/mbx_ram.sv
module mbx_ram #(
  parameter int unsigned DEPTH  = 64,
  parameter int unsigned DATA_W = 8,
  localparam int unsigned AW    = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              h_we,
  input  logic [AW-1:0]     h_addr,
  input  logic [DATA_W-1:0] h_wdata,
  output logic [DATA_W-1:0] h_rdata,
  input  logic              p_we,
  input  logic [AW-1:0]     p_addr,
  input  logic [DATA_W-1:0] p_wdata,
  output logic [DATA_W-1:0] p_rdata
);
  logic [DATA_W-1:0] mem [DEPTH];

  // Per-entry write select; host has priority on an address collision (R11).
  for (genvar i = 0; i < DEPTH; i++) begin : g_ent
    logic h_hit, p_hit;
    assign h_hit = h_we && (h_addr == AW'(i));
    assign p_hit = p_we && (p_addr == AW'(i));
    always_ff @(posedge clk) begin
      if (h_hit)      mem[i] <= h_wdata;
      else if (p_hit) mem[i] <= p_wdata;
    end
  end

  assign h_rdata = mem[h_addr];
  assign p_rdata = mem[p_addr];
endmodule

// File: rtl/mbx_flag.sv
module mbx_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic ld_we,
  input  logic wr_val,
  input  logic done,
  output logic pending
);
  always_ff @(posedge clk) begin
    if (!rst_n)     pending <= 1'b0;
    else if (done)  pending <= 1'b0;
    else if (ld_we) pending <= wr_val;
  end

  assert_done_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !pending);
  assert_load_takes_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_we && !done) |=> pending == $past(wr_val));
  assert_no_load_holds_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!ld_we && !done) |=> $stable(pending));
endmodule

// File: rtl/mbx_host_if.sv
module mbx_host_if
  import mbx_pkg::*;
#(
  parameter int unsigned DEPTH  = 64,
  parameter int unsigned DATA_W = 8,
  localparam int unsigned AW    = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [REG_W-1:0]  reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  input  logic              reg_we,
  input  logic              reg_re,
  output logic [DATA_W-1:0] reg_rdata,
  output logic              ap_req_pending,
  input  logic              ap_done,
  input  logic [AW-1:0]     ap_buf_addr,
  input  logic              ap_buf_we,
  input  logic [DATA_W-1:0] ap_buf_wdata,
  output logic [DATA_W-1:0] ap_buf_rdata,
  output logic              ap_reset,
  input  logic              ap_reset_ack,
  input  logic              ap_running
);
  reg_sel_e          sel;
  logic [AW-1:0]     ptr;
  logic [DATA_W-1:0] host_byte;
  logic              data_wr, data_rd, ptr_wr, flag_wr, ctrl_wr;

  assign sel     = decode(reg_addr);
  assign data_wr = reg_we && (sel == SEL_DATA);
  assign data_rd = reg_re && (sel == SEL_DATA);
  assign ptr_wr  = reg_we && (sel == SEL_PTR);
  assign flag_wr = reg_we && (sel == SEL_FLAG);
  assign ctrl_wr = reg_we && (sel == SEL_CTRL);

  mbx_ptr #(.PTR_W(AW)) u_ptr (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (ptr_wr),
    .load_val (reg_wdata[AW-1:0]),
    .step     (data_wr || data_rd),
    .ptr      (ptr)
  );

  mbx_ram #(.DEPTH(DEPTH), .DATA_W(DATA_W)) u_ram (
    .clk     (clk),
    .h_we    (data_wr),
    .h_addr  (ptr),
    .h_wdata (reg_wdata),
    .h_rdata (host_byte),
    .p_we    (ap_buf_we),
    .p_addr  (ap_buf_addr),
    .p_wdata (ap_buf_wdata),
    .p_rdata (ap_buf_rdata)
  );

  mbx_flag u_flag (
    .clk     (clk),
    .rst_n   (rst_n),
    .ld_we   (flag_wr && reg_wdata[LOAD_BIT]),
    .wr_val  (reg_wdata[FLAG_BIT]),
    .done    (ap_done),
    .pending (ap_req_pending)
  );

  always_ff @(posedge clk) begin
    if (!rst_n)       ap_reset <= 1'b0;
    else if (ctrl_wr) ap_reset <= reg_wdata[RST_BIT];
  end

  logic [DATA_W-1:0] rd_mux;
  always_comb begin
    rd_mux = '0;
    unique case (sel)
      SEL_CTRL:   rd_mux[RST_BIT]  = ap_reset;
      SEL_APSTAT: begin
        rd_mux[ACK_BIT] = ap_reset_ack;
        rd_mux[RUN_BIT] = ap_running;
      end
      SEL_PTR:    rd_mux = DATA_W'(ptr);
      SEL_DATA:   rd_mux = host_byte;
      SEL_FLAG:   rd_mux[FLAG_BIT] = ap_req_pending;
      default:    rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n)      reg_rdata <= '0;
    else if (reg_re) reg_rdata <= rd_mux;
  end

  assert_ctrl_drives_reset_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_wr |=> ap_reset == $past(reg_wdata[RST_BIT]));
  assert_unmapped_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_re && sel == SEL_NONE) |=> reg_rdata == '0);
  assert_apstat_bits_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_re && sel == SEL_APSTAT) |=>
      reg_rdata == {{(DATA_W-2){1'b0}}, $past(ap_running), $past(ap_reset_ack)});
  assert_rdata_holds_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !reg_re |=> $stable(reg_rdata));
endmodule

// File: tb/mbx_host_if_test.sv
module mbx_host_if_test;
  localparam logic [7:0] A_CTRL = 8'hA0, A_STAT = 8'hA2, A_PTR = 8'hA6,
                         A_DATA = 8'hA7, A_FLAG = 8'hA8;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] reg_addr = '0, reg_wdata = '0;
  logic       reg_we = 1'b0, reg_re = 1'b0;
  logic [7:0] reg_rdata;
  logic       ap_req_pending;
  logic       ap_done = 1'b0;
  logic [5:0] ap_buf_addr = '0;
  logic       ap_buf_we = 1'b0;
  logic [7:0] ap_buf_wdata = '0;
  logic [7:0] ap_buf_rdata;
  logic       ap_reset;
  logic       ap_reset_ack = 1'b0, ap_running = 1'b0;

  int checks = 0;
  int fails  = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  mbx_host_if uut (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_we(reg_we), .reg_re(reg_re), .reg_rdata(reg_rdata),
    .ap_req_pending(ap_req_pending), .ap_done(ap_done),
    .ap_buf_addr(ap_buf_addr), .ap_buf_we(ap_buf_we),
    .ap_buf_wdata(ap_buf_wdata), .ap_buf_rdata(ap_buf_rdata),
    .ap_reset(ap_reset), .ap_reset_ack(ap_reset_ack), .ap_running(ap_running)
  );

  // Scoreboard of expected read bytes
  logic [7:0] exp_q[$];
  string      tag_q[$];

  task automatic chk(input int act, input int exp, input string tag);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  // Monitor: read data is due one edge after the strobe is sampled
  always @(posedge clk) begin
    automatic logic pend = reg_re;
    #2;
    if (pend) begin
      if (exp_q.size() == 0) chk(1, 0, "scoreboard underflow");
      else chk(reg_rdata, exp_q.pop_front(), tag_q.pop_front());
    end
  end

  task automatic host_write(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_we = 1'b1;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic host_read(input logic [7:0] a, input logic [7:0] e, input string tag);
    @(negedge clk);
    reg_addr = a; reg_re = 1'b1;
    exp_q.push_back(e); tag_q.push_back(tag);
    @(negedge clk);
    reg_re = 1'b0;
  endtask

  task automatic ap_write(input logic [5:0] a, input logic [7:0] d);
    @(negedge clk);
    ap_buf_addr = a; ap_buf_wdata = d; ap_buf_we = 1'b1;
    @(negedge clk);
    ap_buf_we = 1'b0;
  endtask

  task automatic ap_peek(input logic [5:0] a, input logic [7:0] e, input string tag);
    ap_buf_addr = a;
    #1;
    chk(ap_buf_rdata, e, tag);
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 8);
    checks++; fails++;
    $display("FAIL watchdog: actual hung expected finish");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    chk(ap_req_pending, 0, "R1 pending");
    chk(ap_reset, 0, "R1 ap_reset");
    host_read(A_FLAG, 8'h00, "R1 flag reg");
    host_read(A_CTRL, 8'h00, "R1 ctrl reg");
    host_read(A_PTR,  8'h00, "R1 pointer");
    host_read(A_STAT, 8'h00, "R1 ap status");
    // R10 unmapped addresses
    host_read(8'h55, 8'h00, "R10 unmapped 0x55");
    host_read(8'hA7 + 8'h10, 8'h00, "R10 unmapped 0xB7");

    // R3 command packet: cmd, msg id, payload
    host_write(A_PTR, 8'h00);
    host_write(A_DATA, 8'h11);
    host_write(A_DATA, 8'h22);
    host_write(A_DATA, 8'h33);
    ap_peek(6'd0, 8'h11, "R3 buf[0]");
    ap_peek(6'd1, 8'h22, "R3 buf[1]");
    ap_peek(6'd2, 8'h33, "R3 buf[2]");
    host_read(A_PTR, 8'h03, "R3 pointer advanced");
    // R2 pointer load with upper bits ignored
    host_write(A_PTR, 8'hC5);
    host_read(A_PTR, 8'h05, "R2 pointer load");

    // R6 flag write without load enable is ignored
    host_write(A_FLAG, 8'h01);
    chk(ap_req_pending, 0, "R6 no load enable");
    host_write(A_FLAG, 8'h03);
    chk(ap_req_pending, 1, "R6 loaded");
    host_read(A_FLAG, 8'h01, "R6 readback");

    // R11 processor reply, R7 done
    ap_write(6'd0, 8'hC0);
    ap_write(6'd1, 8'hC1);
    ap_write(6'd2, 8'hD0);
    ap_write(6'd3, 8'hD1);
    @(negedge clk); ap_done = 1'b1;
    @(negedge clk); ap_done = 1'b0;
    chk(ap_req_pending, 0, "R7 done clears");
    host_read(A_FLAG, 8'h00, "R7 flag readback");

    // R4 reply read back, R11 processor bytes visible to host
    host_write(A_PTR, 8'h00);
    host_read(A_DATA, 8'hC0, "R4 reply byte0");
    host_read(A_DATA, 8'hC1, "R4 reply byte1");
    host_read(A_DATA, 8'hD0, "R11 reply byte2");
    host_read(A_DATA, 8'hD1, "R11 reply byte3");
    host_read(A_PTR, 8'h04, "R4 pointer advanced");
    host_read(A_PTR, 8'h04, "R10 non-data read keeps pointer");

    // R5 wrap on write and on read
    host_write(A_PTR, 8'h3F);
    host_write(A_DATA, 8'hAA);
    host_write(A_DATA, 8'hBB);
    host_read(A_PTR, 8'h01, "R5 write wrap pointer");
    ap_peek(6'd63, 8'hAA, "R5 buf[63]");
    ap_peek(6'd0, 8'hBB, "R5 buf[0]");
    host_write(A_PTR, 8'h3F);
    host_read(A_DATA, 8'hAA, "R5 read at 63");
    host_read(A_DATA, 8'hBB, "R5 read after wrap");
    host_read(A_PTR, 8'h01, "R5 read wrap pointer");

    // R11 host wins on a same-address collision
    @(negedge clk);
    reg_addr = A_PTR; reg_wdata = 8'h08; reg_we = 1'b1;
    @(negedge clk);
    reg_addr = A_DATA; reg_wdata = 8'h5A;
    ap_buf_addr = 6'd8; ap_buf_wdata = 8'hA5; ap_buf_we = 1'b1;
    @(negedge clk);
    reg_we = 1'b0; ap_buf_we = 1'b0;
    ap_peek(6'd8, 8'h5A, "R11 host priority");

    // R6 stale request cleared by writing 0 with load enable
    host_write(A_FLAG, 8'h03);
    host_write(A_FLAG, 8'h02);
    chk(ap_req_pending, 0, "R6 stale clear");

    // R7 done wins over simultaneous flag load
    host_write(A_FLAG, 8'h03);
    @(negedge clk);
    reg_addr = A_FLAG; reg_wdata = 8'h03; reg_we = 1'b1; ap_done = 1'b1;
    @(negedge clk);
    reg_we = 1'b0; ap_done = 1'b0;
    chk(ap_req_pending, 0, "R7 done beats write");

    // R8 reset control, R9 status indications
    host_write(A_CTRL, 8'h01);
    chk(ap_reset, 1, "R8 reset asserted");
    host_read(A_CTRL, 8'h01, "R8 ctrl readback");
    ap_reset_ack = 1'b1;
    host_read(A_STAT, 8'h01, "R9 reset ack");
    host_write(A_CTRL, 8'h00);
    chk(ap_reset, 0, "R8 reset released");
    ap_reset_ack = 1'b0; ap_running = 1'b1;
    host_read(A_STAT, 8'h02, "R9 running");

    repeat (4) @(negedge clk);
    chk(exp_q.size(), 0, "scoreboard drained");
    finish_run();
  end
endmodule